// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address, bank and clock-enable pins of a single-data-rate SDRAM from reset until the memory is usable. It first holds the bus idle for a long power-up interval. It then closes every bank and runs the auto refresh cycles. It also writes the mode register, either after or before the refreshes, depending on a parameter. When the last timing gap has elapsed, it raises a ready flag. A memory controller takes the pins over after that flag is high.

All timing gaps are counted in clock cycles of a 100 MHz clock. The row-precharge and refresh-cycle times are given in nanoseconds and rounded up to whole cycles, which gives 2 and 6 cycles by default. The mode-register gap is a fixed cycle count of 2. The power-up interval is a plain cycle count, 10,000 by default, and a shorter value can be set for simulation.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer. Cycle n below means the state of the outputs after the n-th rising clock edge that follows the deassertion of `rst_n`. Because of the synchronizer, the sequence proper starts in cycle 3.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: CKE is 0, the command is NOP, address and bank are 0, and `init_done` is 0. The command pins {cs_n,ras_n,cas_n,we_n} encode NOP as 0111, PRECHARGE as 0010, AUTO REFRESH as 0001 and LOAD MODE as 0000.
- R2: CKE is 0 in cycles 1 and 2, rises in cycle 3, and stays high until the next reset.
- R3: No command other than NOP appears before cycle POWERUP_CYC+3.
- R4: Cycle POWERUP_CYC+3 carries PRECHARGE with address bit 10 set and all other address bits 0, which closes all banks. It is the only PRECHARGE in the sequence.
- R5: With MODE_FIRST=0, exactly NUM_REF (default 2) AUTO REFRESH commands are issued. The first comes 2 cycles after the PRECHARGE, and the two are 6 cycles apart.
- R6: LOAD MODE drives bank 0 and an address word with these fields:
  - bits [2:0] = 111, meaning full-page burst;
  - bit 3 = 0, meaning sequential order;
  - bits [6:4] = CAS latency 3;
  - all other bits 0.

  With MODE_FIRST=0, it comes 6 cycles after the last AUTO REFRESH.
- R7: `init_done` rises exactly 2 cycles after the final command of the sequence, and stays high. From then on, only NOP is driven.
- R8: With MODE_FIRST=1, the order changes as follows. LOAD MODE comes 2 cycles after the PRECHARGE. The first AUTO REFRESH follows 2 cycles later, and the next one 6 cycles after that. `init_done` rises 6 cycles after the last AUTO REFRESH.
- R9: In every cycle that carries NOP, the address and bank outputs are 0.
- R10: Asserting `rst_n` in mid-sequence immediately returns the outputs to the R1 state. After release, the sequence restarts with the full power-up interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | AW (13) | Address bus |
| sd_ba | output | BW (2) | Bank select |
| init_done | output | 1 | High once the device may accept normal commands |

## Verification
The assertions assume a free-running clock. They also assume that `rst_n` is the only input, and that it may be released at any phase, because their own reset is the synchronized one. The stimulus changes `rst_n` only just after a falling clock edge. It holds the reset for several cycles before each release. One reset is applied in mid-sequence, so that the restart path is exercised under the same assumptions.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_POWER,
    ST_REF,
    ST_LMR,
    ST_DONE
  } init_step_e;

  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int unsigned W       = 14,
  parameter int unsigned RST_VAL = 10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(RST_VAL);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R7
  timer_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_init_pkg::*;
#(
  parameter int unsigned GW         = 14,
  parameter int unsigned NUM_REF    = 2,
  parameter bit          MODE_FIRST = 1'b0,
  parameter int unsigned TRP_CYC    = 2,
  parameter int unsigned TRFC_CYC   = 6,
  parameter int unsigned TMRD_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gap_zero,
  output sdr_cmd_e      issue_cmd,
  output logic          gap_load,
  output logic [GW-1:0] gap_val,
  output logic          done_set
);

  localparam int unsigned RW = $clog2(NUM_REF + 1);

  init_step_e step_q, step_d;
  logic [RW-1:0] ref_q, ref_d;
  logic step_en;

  init_step_e after_pre;
  init_step_e after_ref;
  init_step_e after_lmr;

  generate
    if (MODE_FIRST) begin : g_mode_first
      assign after_pre = ST_LMR;
      assign after_lmr = ST_REF;
      assign after_ref = ST_DONE;
    end else begin : g_ref_first
      assign after_pre = ST_REF;
      assign after_ref = ST_LMR;
      assign after_lmr = ST_DONE;
    end
  endgenerate

  always_comb begin
    issue_cmd = CMD_NOP;
    gap_load  = 1'b0;
    gap_val   = '0;
    done_set  = 1'b0;
    step_d    = step_q;
    ref_d     = ref_q;
    if (gap_zero) begin
      unique case (step_q)
        ST_POWER: begin
          issue_cmd = CMD_PRE;
          gap_load  = 1'b1;
          gap_val   = GW'(TRP_CYC - 1);
          step_d    = after_pre;
        end
        ST_REF: begin
          issue_cmd = CMD_REF;
          gap_load  = 1'b1;
          gap_val   = GW'(TRFC_CYC - 1);
          ref_d     = ref_q + 1'b1;
          if (ref_q == RW'(NUM_REF - 1)) begin
            step_d = after_ref;
          end
        end
        ST_LMR: begin
          issue_cmd = CMD_LMR;
          gap_load  = 1'b1;
          gap_val   = GW'(TMRD_CYC - 1);
          step_d    = after_lmr;
        end
        ST_DONE: begin
          done_set = 1'b1;
        end
        default: begin
          step_d = step_q;
        end
      endcase
    end
  end

  assign step_en = gap_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_POWER;
      ref_q  <= '0;
    end else if (step_en) begin
      step_q <= step_d;
      ref_q  <= ref_d;
    end
  end

  // R5
  ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_REF) |-> (ref_q < RW'(NUM_REF)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_DONE) |=> (step_q == ST_DONE));

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_init_pkg::*;
#(
  parameter int unsigned AW      = 13,
  parameter int unsigned BW      = 2,
  parameter int unsigned CAS_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sdr_cmd_e      issue_cmd,
  input  logic          done_set,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba,
  output logic          init_done
);

  localparam logic [AW-1:0] PRE_ALL_WORD = AW'(32'h400);
  localparam logic [AW-1:0] MODE_WORD    = AW'(32'h7 | ((CAS_LAT % 8) << 4));

  sdr_cmd_e      cmd_q;
  logic [AW-1:0] addr_q, addr_d;
  logic          cke_q;
  logic          done_q;

  always_comb begin
    unique case (issue_cmd)
      CMD_PRE: addr_d = PRE_ALL_WORD;
      CMD_LMR: addr_d = MODE_WORD;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      cke_q  <= 1'b0;
    end else begin
      cmd_q  <= issue_cmd;
      addr_q <= addr_d;
      cke_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_set) begin
      done_q <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign cke       = cke_q;
  assign init_done = done_q;

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_q |=> cke_q);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && (cmd_q == CMD_NOP)));

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (addr_q == PRE_ALL_WORD));

  // R6
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_LMR) |-> ((addr_q[2:0] == 3'b111) && !addr_q[3] &&
                            (addr_q[6:4] == 3'(CAS_LAT))));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (addr_q == '0));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdr_init_pkg::*;
#(
  parameter int unsigned POWERUP_CYC = 10000,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned TRP_NS      = 20,
  parameter int unsigned TRFC_NS     = 60,
  parameter int unsigned TMRD_CYC    = 2,
  parameter int unsigned NUM_REF     = 2,
  parameter bit          MODE_FIRST  = 1'b0,
  parameter int unsigned CAS_LAT     = 3,
  parameter int unsigned AW          = 13,
  parameter int unsigned BW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          sd_cke,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic [AW-1:0] sd_addr,
  output logic [BW-1:0] sd_ba,
  output logic          init_done
);

  localparam int unsigned TRP_CYC  = ns_to_cyc(TRP_NS, CLK_NS);
  localparam int unsigned TRFC_CYC = ns_to_cyc(TRFC_NS, CLK_NS);
  localparam int unsigned MAX_GAP  = max_of(max_of(TRP_CYC, TRFC_CYC), TMRD_CYC);
  localparam int unsigned GW       = $clog2(max_of(POWERUP_CYC, MAX_GAP) + 1);
  localparam int unsigned UW       = $clog2(POWERUP_CYC + 2);
  localparam int unsigned SW       = $clog2(MAX_GAP + 2);

  logic          rst_i_n;
  logic          gap_zero;
  logic          gap_load;
  logic [GW-1:0] gap_val;
  logic          done_set;
  sdr_cmd_e      issue_cmd;

  sdr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sdr_gap_timer #(
    .W       (GW),
    .RST_VAL (POWERUP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  sdr_init_fsm #(
    .GW         (GW),
    .NUM_REF    (NUM_REF),
    .MODE_FIRST (MODE_FIRST),
    .TRP_CYC    (TRP_CYC),
    .TRFC_CYC   (TRFC_CYC),
    .TMRD_CYC   (TMRD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .gap_zero  (gap_zero),
    .issue_cmd (issue_cmd),
    .gap_load  (gap_load),
    .gap_val   (gap_val),
    .done_set  (done_set)
  );

  sdr_cmd_drive #(
    .AW      (AW),
    .BW      (BW),
    .CAS_LAT (CAS_LAT)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .issue_cmd (issue_cmd),
    .done_set  (done_set),
    .cke       (sd_cke),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .addr      (sd_addr),
    .ba        (sd_ba),
    .init_done (init_done)
  );

  // Spacing observer on the pins: cycles since reset, last command, gap since it
  logic [3:0]    pin_cmd;
  logic [UW-1:0] up_q;
  logic [SW-1:0] since_q;
  logic [3:0]    last_q;
  logic          seen_q;
  logic [SW-1:0] need_gap;
  logic          is_cmd;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd  = (pin_cmd != CMD_NOP);

  always_comb begin
    unique case (last_q)
      CMD_PRE: need_gap = SW'(TRP_CYC);
      CMD_REF: need_gap = SW'(TRFC_CYC);
      CMD_LMR: need_gap = SW'(TMRD_CYC);
      default: need_gap = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      up_q    <= '0;
      since_q <= '0;
      last_q  <= CMD_NOP;
      seen_q  <= 1'b0;
    end else begin
      if (up_q <= UW'(POWERUP_CYC)) begin
        up_q <= up_q + 1'b1;
      end
      if (is_cmd) begin
        since_q <= SW'(1);
        last_q  <= pin_cmd;
        seen_q  <= 1'b1;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R3
  powerup_wait_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (is_cmd && !seen_q) |-> ((up_q > UW'(POWERUP_CYC)) && (pin_cmd == CMD_PRE)));

  // R4
  single_pre_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pin_cmd == CMD_PRE) |-> !seen_q);

  // R5
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (is_cmd && seen_q) |-> (since_q >= need_gap));

  // R9
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !is_cmd |-> (sd_ba == '0));

endmodule

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;

  localparam int SHORT_WAIT = 40;
  localparam int LONG_WAIT  = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cke0, cs0, ras0, cas0, we0, done0_o;
  logic [12:0] addr0;
  logic [1:0]  ba0;
  logic        cke1, cs1, ras1, cas1, we1, done1_o;
  logic [12:0] addr1;
  logic [1:0]  ba1;

  sdram_pwrup_seq u0 (
    .clk(clk), .rst_n(rst_n), .sd_cke(cke0), .sd_cs_n(cs0), .sd_ras_n(ras0),
    .sd_cas_n(cas0), .sd_we_n(we0), .sd_addr(addr0), .sd_ba(ba0), .init_done(done0_o)
  );

  sdram_pwrup_seq #(.POWERUP_CYC(SHORT_WAIT), .MODE_FIRST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .sd_cke(cke1), .sd_cs_n(cs1), .sd_ras_n(ras1),
    .sd_cas_n(cas1), .sd_we_n(we1), .sd_addr(addr1), .sd_ba(ba1), .init_done(done1_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int         ev0_cyc[8];
  logic [3:0] ev0_cmd[8];
  logic [12:0] ev0_addr[8];
  logic [1:0] ev0_ba[8];
  int         n0, done0, bad0;
  int         ev1_cyc[8];
  logic [3:0] ev1_cmd[8];
  logic [12:0] ev1_addr[8];
  logic [1:0] ev1_ba[8];
  int         n1, done1, bad1;

  task automatic clear_logs();
    n0 = 0; done0 = -1; bad0 = 0;
    n1 = 0; done1 = -1; bad1 = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc = cyc + 1;
      if ({cs0, ras0, cas0, we0} != 4'b0111) begin
        if (n0 < 8) begin
          ev0_cyc[n0] = cyc; ev0_cmd[n0] = {cs0, ras0, cas0, we0};
          ev0_addr[n0] = addr0; ev0_ba[n0] = ba0;
        end
        n0 = n0 + 1;
        if (done0 >= 0) bad0 = bad0 + 1;
      end else if (addr0 != 13'd0 || ba0 != 2'd0) begin
        bad0 = bad0 + 1;
      end
      if ((cyc >= 3) != cke0) bad0 = bad0 + 1;
      if (done0 >= 0 && !done0_o) bad0 = bad0 + 1;
      if (done0 < 0 && done0_o) done0 = cyc;

      if ({cs1, ras1, cas1, we1} != 4'b0111) begin
        if (n1 < 8) begin
          ev1_cyc[n1] = cyc; ev1_cmd[n1] = {cs1, ras1, cas1, we1};
          ev1_addr[n1] = addr1; ev1_ba[n1] = ba1;
        end
        n1 = n1 + 1;
        if (done1 >= 0) bad1 = bad1 + 1;
      end else if (addr1 != 13'd0 || ba1 != 2'd0) begin
        bad1 = bad1 + 1;
      end
      if ((cyc >= 3) != cke1) bad1 = bad1 + 1;
      if (done1 >= 0 && !done1_o) bad1 = bad1 + 1;
      if (done1 < 0 && done1_o) done1 = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_ev(input int inst, input int idx, input int exp_cyc,
                        input logic [3:0] exp_cmd, input logic [12:0] exp_addr,
                        input string tag);
    int a_cyc; logic [3:0] a_cmd; logic [12:0] a_addr; logic [1:0] a_ba;
    if (inst == 0) begin
      a_cyc = ev0_cyc[idx]; a_cmd = ev0_cmd[idx]; a_addr = ev0_addr[idx]; a_ba = ev0_ba[idx];
    end else begin
      a_cyc = ev1_cyc[idx]; a_cmd = ev1_cmd[idx]; a_addr = ev1_addr[idx]; a_ba = ev1_ba[idx];
    end
    chk(a_cyc == exp_cyc, tag, $sformatf("u%0d command %0d cycle", inst, idx), a_cyc, exp_cyc);
    chk(a_cmd == exp_cmd, tag, $sformatf("u%0d command %0d code", inst, idx), a_cmd, exp_cmd);
    chk(a_addr == exp_addr && a_ba == 2'd0, tag,
        $sformatf("u%0d command %0d address", inst, idx), a_addr, exp_addr);
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    clear_logs();
    #1 rst_n = 1'b1;
  endtask

  // R1: outputs while reset is held
  task automatic test_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(cke0 == 1'b0, "R1", "u0 cke in reset", cke0, 0);
    chk({cs0, ras0, cas0, we0} == 4'b0111, "R1", "u0 command in reset", {cs0, ras0, cas0, we0}, 7);
    chk(addr0 == 13'd0 && ba0 == 2'd0, "R1", "u0 address in reset", addr0, 0);
    chk(done0_o == 1'b0 && done1_o == 1'b0, "R1", "init_done in reset", done0_o, 0);
  endtask

  // R2 R3 R4 R5 R6 R7 R9 (u0) and R8 (u1) over one full run
  task automatic test_full_run();
    start_run();
    repeat (LONG_WAIT + 30) @(negedge clk);
    #1;
    chk(n0 == 4, "R5", "u0 command count", n0, 4);
    chk(ev0_cyc[0] == LONG_WAIT + 3, "R3", "u0 first non-NOP cycle", ev0_cyc[0], LONG_WAIT + 3);
    chk_ev(0, 0, LONG_WAIT + 3, 4'b0010, 13'h400, "R4");
    chk_ev(0, 1, LONG_WAIT + 5, 4'b0001, 13'h000, "R5");
    chk_ev(0, 2, LONG_WAIT + 11, 4'b0001, 13'h000, "R5");
    chk_ev(0, 3, LONG_WAIT + 17, 4'b0000, 13'h037, "R6");
    chk(done0 == LONG_WAIT + 19, "R7", "u0 init_done rise cycle", done0, LONG_WAIT + 19);
    chk(bad0 == 0, "R9", "u0 idle bus / cke / done-hold violations", bad0, 0);
    chk(n1 == 4, "R8", "u1 command count", n1, 4);
    chk_ev(1, 0, SHORT_WAIT + 3, 4'b0010, 13'h400, "R4");
    chk_ev(1, 1, SHORT_WAIT + 5, 4'b0000, 13'h037, "R8");
    chk_ev(1, 2, SHORT_WAIT + 7, 4'b0001, 13'h000, "R8");
    chk_ev(1, 3, SHORT_WAIT + 13, 4'b0001, 13'h000, "R8");
    chk(done1 == SHORT_WAIT + 19, "R8", "u1 init_done rise cycle", done1, SHORT_WAIT + 19);
    chk(bad1 == 0, "R2", "u1 cke / idle bus / done-hold violations", bad1, 0);
  endtask

  // R10: reset in mid-sequence, then a full restart
  task automatic test_midrun_reset();
    start_run();
    repeat (SHORT_WAIT + 6) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(cke1 == 1'b0, "R10", "u1 cke right after reset", cke1, 0);
    chk({cs1, ras1, cas1, we1} == 4'b0111 && addr1 == 13'd0, "R10", "u1 bus right after reset",
        {cs1, ras1, cas1, we1}, 7);
    chk(n1 == 2, "R10", "u1 commands before interrupt", n1, 2);
    start_run();
    repeat (SHORT_WAIT + 30) @(negedge clk);
    #1;
    chk(n1 == 4, "R10", "u1 command count after restart", n1, 4);
    chk_ev(1, 0, SHORT_WAIT + 3, 4'b0010, 13'h400, "R10");
    chk(done1 == SHORT_WAIT + 19, "R10", "u1 init_done after restart", done1, SHORT_WAIT + 19);
    chk(n0 == 0 && done0 < 0, "R10", "u0 still waiting after restart", n0, 0);
    chk(bad0 == 0 && bad1 == 0, "R10", "violations after restart", bad0 + bad1, 0);
  endtask

  initial begin
    clear_logs();
    test_reset_state();
    test_full_run();
    test_midrun_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all R): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule